// File: doc/BRIEF.md
# Stationary-Coefficient Systolic FIR Filter

This block is a linear systolic FIR filter of `TAPS` processing elements. Every element holds one coefficient for the whole run. Two streams run past the coefficients in the same direction: the input samples and the partial sums. The two streams move at different rates, so each partial sum meets every sample it needs without any broadcast wire. The array takes one new sample every clock and gives one filter result every clock. No element is ever idle.

The `FLOW` parameter picks one of two arrangements. In the forward arrangement, samples and sums both enter at element 0. Samples take two registers per hop and sums take one. In the reverse arrangement, both streams enter at element `TAPS-1` and travel toward element 0. There samples take one register per hop and sums take two. The last sum register of the final hop is left out, so both arrangements have the same latency.

Coefficients are written one tap at a time through a load port. They are normally loaded while no samples are in flight. A valid flag travels with the data, so the result valid lines up with its result in both arrangements.

Top module: `ws_systolic_fir`

## Requirements
- R1: The reset is synchronous and active low. After it, `result_data` and `result_valid` are 0 and every coefficient is 0, so a later sample stream gives zero results until coefficients are loaded.
- R2: When `coef_valid` is high at a rising edge, `coef_data` becomes coefficient h[k], with k = `coef_addr`. It applies from that edge on. Coefficient h[k] multiplies the sample that is k positions older than the newest sample of the sum.
- R3: When `coef_valid` is low, `coef_addr` and `coef_data` have no effect on any coefficient.
- R4: In the forward arrangement (`FLOW` = forward), `result_data` becomes y(n) = sum over k of h[k]·x(n−k) exactly `TAPS` rising edges after the edge that accepted sample x(n).
- R5: The reverse arrangement (`FLOW` = reverse) produces the same y(n) with the same latency of `TAPS` edges as R4.
- R6: `result_valid` equals `sample_valid` delayed by `TAPS` rising edges, in both arrangements.
- R7: A cycle with `sample_valid` low enters the array as a zero sample, whatever `sample_data` holds.
- R8: `result_data` is signed and DATA_W+COEF_W+clog2(TAPS) bits wide. It does not wrap when every sample and every coefficient sits at the most negative or most positive value.
- R9: The array accepts a sample on every cycle. A run of back-to-back valid samples gives a run of back-to-back valid results of the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| coef_valid | input | 1 | Coefficient write strobe |
| coef_addr | input | clog2(TAPS) | Tap index k of the coefficient being written |
| coef_data | input | COEF_W | Signed coefficient value |
| sample_valid | input | 1 | Marks `sample_data` as a real sample |
| sample_data | input | DATA_W | Signed input sample |
| result_valid | output | 1 | Marks `result_data` as the result of a real sample |
| result_data | output | DATA_W+COEF_W+clog2(TAPS) | Signed filter output |

## Verification
The bench drives a forward and a reverse instance with the same stimulus and compares both against one reference convolution.

- A single unit impulse must bring the loaded coefficients out in tap order. This separates correct tap placement from a reversed array, which is the main way the reverse arrangement can go wrong.
- A mixed table of samples tests the gating and the alignment between result data and result valid. It holds samples of both signs, gaps whose data is not zero, and back-to-back runs.
- Full-scale negative samples and coefficients test the accumulator width.
- A write with the strobe low, and a reset in the middle of a stream followed by an impulse, show that the coefficients change only through a strobed write.

// File: rtl/sfir_pkg.sv
// Shared definitions for the stationary-coefficient systolic FIR.
// Holds the flow-direction type and the per-hop register counts
// that follow from it.
package sfir_pkg;

    // Direction of both streams through the array.
    typedef enum logic {
        FLOW_FWD = 1'b0,   // streams enter at element 0
        FLOW_REV = 1'b1    // streams enter at element TAPS-1
    } flow_e;

    // Registers the sample stream takes between two neighbouring elements.
    function automatic int x_link_dly(flow_e f);
        return (f == FLOW_FWD) ? 2 : 1;
    endfunction

    // Registers the partial sum takes after an element.
    // The final hop of the reverse form keeps a single register, so both
    // forms share the same latency.
    function automatic int sum_hop_dly(flow_e f, bit last_hop);
        return (f == FLOW_FWD || last_hop) ? 1 : 2;
    endfunction

endpackage

// File: rtl/sfir_delay.sv
// Fixed-length register delay line.
// Assumes DLY >= 1. Every stage clears to zero on the synchronous
// active-low reset.
module sfir_delay #(
    parameter int W   = 8,
    parameter int DLY = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [DLY];

    // Shift the word one stage further along on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DLY; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DLY; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DLY-1];

    // R4
    dly_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, DLY)) |-> (q == $past(d, DLY)));

endmodule

// File: rtl/sfir_coef_bank.sv
// Coefficient store: one register for each tap.
// A write is accepted only when the strobe is high and the address
// decodes to an existing tap. Any other address is dropped.
module sfir_coef_bank #(
    parameter int TAPS   = 4,
    parameter int COEF_W = 8,
    localparam int AW    = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    output logic signed [COEF_W-1:0] coef_q [TAPS]
);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic hit;
        assign hit = wr_en && (wr_addr == AW'(k));

        // Capture this tap's coefficient when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)   coef_q[k] <= '0;
            else if (hit) coef_q[k] <= wr_data;
        end

        // R2
        coef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(k)) |=> (coef_q[k] == $past(wr_data)));

        // R3
        coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == AW'(k)) |=> $stable(coef_q[k]));
    end

endmodule

// File: rtl/sfir_pe.sv
// One processing element of the array.
// It adds coefficient times sample to the incoming partial sum, then
// registers the total SUM_DLY times. The valid flag takes one register,
// matching the stream that moves one register per hop.
// Assumes ACC_W is wide enough to hold the full product.
module sfir_pe #(
    parameter int DATA_W  = 8,
    parameter int COEF_W  = 8,
    parameter int ACC_W   = 18,
    parameter int SUM_DLY = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [ACC_W-1:0]  s_in,
    input  logic                     v_in,
    output logic signed [ACC_W-1:0]  s_out,
    output logic                     v_out
);

    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] mac;

    assign prod = ACC_W'(x) * ACC_W'(coef);
    assign mac  = s_in + prod;

    sfir_delay #(.W(ACC_W), .DLY(SUM_DLY)) u_sum_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mac),
        .q     (s_out)
    );

    sfir_delay #(.W(1), .DLY(1)) u_vld_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (v_in),
        .q     (v_out)
    );

    // R7
    zero_sample_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, SUM_DLY) && $past(x, SUM_DLY) == 0)
        |-> (s_out == $past(s_in, SUM_DLY)));

endmodule

// File: rtl/ws_systolic_fir.sv
// Stationary-coefficient systolic FIR top level.
// Builds TAPS elements in the order of flow (hop 0 first) and places a
// sample delay line between each pair of neighbours.
// FLOW sets the per-hop register counts: the forward form uses 2 for
// samples and 1 for sums, the reverse form 1 for samples and 2 for sums.
// A hop of the reverse form sits at element TAPS-1-hop, and that element
// still holds coefficient h[element].
// Assumes coefficients change only while no samples are in flight.
module ws_systolic_fir
    import sfir_pkg::*;
#(
    parameter int    TAPS   = 4,
    parameter int    DATA_W = 8,
    parameter int    COEF_W = 8,
    parameter flow_e FLOW   = FLOW_FWD
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       coef_valid,
    input  logic [((TAPS > 1) ? $clog2(TAPS) : 1)-1:0] coef_addr,
    input  logic signed [COEF_W-1:0]                   coef_data,
    input  logic                                       sample_valid,
    input  logic signed [DATA_W-1:0]                   sample_data,
    output logic                                       result_valid,
    output logic signed [DATA_W+COEF_W+((TAPS > 1) ? $clog2(TAPS) : 1)-1:0] result_data
);

    localparam int AW    = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam int ACC_W = DATA_W + COEF_W + AW;
    localparam int XD    = x_link_dly(FLOW);

    logic signed [COEF_W-1:0] coef_q [TAPS];
    logic signed [DATA_W-1:0] x_hop  [TAPS];
    logic signed [ACC_W-1:0]  s_hop  [TAPS+1];
    logic                     v_hop  [TAPS+1];

    sfir_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_valid),
        .wr_addr (coef_addr),
        .wr_data (coef_data),
        .coef_q  (coef_q)
    );

    // A cycle without a valid sample enters the array as a zero.
    assign x_hop[0] = sample_valid ? sample_data : '0;
    assign s_hop[0] = '0;
    assign v_hop[0] = sample_valid;

    for (genvar m = 0; m < TAPS; m++) begin : g_hop
        localparam int PHYS = (FLOW == FLOW_FWD) ? m : TAPS - 1 - m;
        localparam int SD   = sum_hop_dly(FLOW, m == TAPS - 1);

        sfir_pe #(
            .DATA_W  (DATA_W),
            .COEF_W  (COEF_W),
            .ACC_W   (ACC_W),
            .SUM_DLY (SD)
        ) u_pe (
            .clk   (clk),
            .rst_n (rst_n),
            .x     (x_hop[m]),
            .coef  (coef_q[PHYS]),
            .s_in  (s_hop[m]),
            .v_in  (v_hop[m]),
            .s_out (s_hop[m+1]),
            .v_out (v_hop[m+1])
        );

        if (m < TAPS - 1) begin : g_link
            sfir_delay #(.W(DATA_W), .DLY(XD)) u_x_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (x_hop[m]),
                .q     (x_hop[m+1])
            );
        end
    end

    assign result_data  = s_hop[TAPS];
    assign result_valid = v_hop[TAPS];

endmodule

// File: tb/tb_ws_systolic_fir.sv
`timescale 1ns/1ps
// Bench for both flow forms of the stationary-coefficient systolic FIR.
// The two instances share every input. Each is compared on every cycle
// with a reference convolution kept inside the bench.
module tb_ws_systolic_fir;

    localparam int TAPS   = 4;
    localparam int DATA_W = 8;
    localparam int COEF_W = 8;
    localparam int AW     = $clog2(TAPS);
    localparam int ACC_W  = DATA_W + COEF_W + AW;
    localparam int NSTIM  = 24;
    localparam int HIST   = 512;

    // Stimulus table: sample value and valid flag for each entry.
    localparam int STIM_X [NSTIM] = '{10, -7, 55, 127, -128, 1, 2, 3, -9, 44,
                                      64, -64, 100, -100, 33, 77, 12, 12, 12,
                                      -1, -1, 127, 127, 5};
    localparam bit STIM_V [NSTIM] = '{1, 1, 0, 1, 1, 1, 1, 1, 0, 0,
                                      1, 1, 1, 1, 1, 0, 1, 1, 1,
                                      1, 1, 1, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coef_valid = 1'b0;
    logic [AW-1:0] coef_addr = '0;
    logic signed [COEF_W-1:0] coef_data = '0;
    logic sample_valid = 1'b0;
    logic signed [DATA_W-1:0] sample_data = '0;
    logic res_v_f, res_v_r;
    logic signed [ACC_W-1:0] res_f, res_r;

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    longint xg [HIST];
    bit vg [HIST];
    longint hm [TAPS];

    always #10 clk = ~clk;

    ws_systolic_fir #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
                      .FLOW(sfir_pkg::FLOW_FWD)) dut (
        .clk(clk), .rst_n(rst_n), .coef_valid(coef_valid), .coef_addr(coef_addr),
        .coef_data(coef_data), .sample_valid(sample_valid), .sample_data(sample_data),
        .result_valid(res_v_f), .result_data(res_f));

    ws_systolic_fir #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
                      .FLOW(sfir_pkg::FLOW_REV)) dut_dual (
        .clk(clk), .rst_n(rst_n), .coef_valid(coef_valid), .coef_addr(coef_addr),
        .coef_data(coef_data), .sample_valid(sample_valid), .sample_data(sample_data),
        .result_valid(res_v_r), .result_data(res_r));

    task automatic check(string tag, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    function automatic longint exp_y(int i);
        longint acc = 0;
        for (int k = 0; k < TAPS; k++)
            if (i - k >= 0) acc += hm[k] * xg[i-k];
        return acc;
    endfunction

    // Check the outputs for the sample TAPS edges back, then apply one cycle of input.
    task automatic cycle(string tag, bit sv, int sd, bit cv, int ca, int cd);
        int i = cnt - TAPS;
        longint ey = (i >= 0) ? exp_y(i) : 0;
        bit ev = (i >= 0) ? vg[i] : 1'b0;
        check(tag, "R4 forward result", res_f, ey);
        check(tag, "R5 reverse result", res_r, ey);
        check(tag, "R6 forward valid", longint'(res_v_f), longint'(ev));
        check(tag, "R6 reverse valid", longint'(res_v_r), longint'(ev));
        sample_valid = sv;
        sample_data  = DATA_W'(sd);
        coef_valid   = cv;
        coef_addr    = AW'(ca);
        coef_data    = COEF_W'(cd);
        xg[cnt] = sv ? longint'(sample_data) : 0;
        vg[cnt] = sv;
        if (cv && ca < TAPS) hm[ca] = longint'(coef_data);
        @(posedge clk);
        @(negedge clk);
        cnt++;
    endtask

    task automatic idle(string tag, int n);
        for (int j = 0; j < n; j++) cycle(tag, 1'b0, 0, 1'b0, 0, 0);
    endtask

    // Hold reset for two edges, check the cleared outputs, then release and clear the model.
    task automatic do_reset();
        rst_n = 1'b0;
        sample_valid = 1'b0; sample_data = '0;
        coef_valid = 1'b0; coef_addr = '0; coef_data = '0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R1", "forward result in reset", res_f, 0);
        check("R1", "reverse result in reset", res_r, 0);
        check("R1", "forward valid in reset", longint'(res_v_f), 0);
        check("R1", "reverse valid in reset", longint'(res_v_r), 0);
        rst_n = 1'b1;
        cnt = 0;
        for (int k = 0; k < TAPS; k++) hm[k] = 0;
        for (int j = 0; j < HIST; j++) begin xg[j] = 0; vg[j] = 1'b0; end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog got running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        idle("R1", 2);

        // R2: load taps, then an impulse must return the taps in order
        cycle("R2", 1'b0, 0, 1'b1, 0, 3);
        cycle("R2", 1'b0, 0, 1'b1, 1, -2);
        cycle("R2", 1'b0, 0, 1'b1, 2, 5);
        cycle("R2", 1'b0, 0, 1'b1, 3, 7);
        cycle("R2", 1'b1, 1, 1'b0, 0, 0);
        idle("R2", 8);

        // R7 R9: table walk with gaps and back-to-back runs
        for (int t = 0; t < NSTIM; t++)
            cycle("R7 R9 table", STIM_V[t], STIM_X[t], 1'b0, 0, 0);
        idle("R7 R9 flush", 12);

        // R3: strobe low with live address and data must change nothing
        cycle("R3", 1'b0, 0, 1'b0, 2, -50);
        cycle("R3", 1'b0, 0, 1'b0, 0, 99);
        cycle("R3", 1'b1, 2, 1'b0, 1, -77);
        idle("R3", 8);
        idle("R8 flush", 4);

        // R8: full-scale negative values, then mixed full scale
        for (int k = 0; k < TAPS; k++) cycle("R8", 1'b0, 0, 1'b1, k, -128);
        for (int j = 0; j < 6; j++) cycle("R8", 1'b1, -128, 1'b0, 0, 0);
        for (int j = 0; j < 3; j++) cycle("R8", 1'b1, 127, 1'b0, 0, 0);
        idle("R8", 10);

        // R1: reset in the middle of a stream clears the coefficients
        for (int j = 0; j < 3; j++) cycle("R1", 1'b1, 9, 1'b0, 0, 0);
        do_reset();
        cycle("R1", 1'b1, 5, 1'b0, 0, 0);
        idle("R1", 8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule